// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores incoming receive frames into a circular buffer that lives in a byte-wide local RAM. The RAM is divided into 256-byte pages, and the ring covers the pages from a first-page register up to, but not including, a limit page. Frames arrive as a byte stream with a valid/ready handshake and start/end markers. Each accepted frame takes space from the current page onward. Its payload begins four bytes into that page, and its four-byte header is written last. The header holds the receive status, the page where the next frame will start, and the stored length.

Frames that are shorter than the minimum size are filled with zero bytes up to 60 bytes. Payload addresses that reach the limit page continue at the first page of the ring. When a frame has been stored, the current page pointer moves to the precomputed next page and a one-cycle receive-done request is raised. The block reports buffer-full status at all times. Frames that start while the block is stopped or full are still consumed from the stream, but nothing from them is written. The host can load the current page pointer directly.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `in_ready` is 1, `mem_we` is 0, `rx_irq` is 0 and `cur_pg` is 0.
- R2: `buf_full` is 1 when the free space is fewer than 1518 bytes. Positions are page×256. If current < boundary, the free space is boundary − current. Otherwise it is (limit − first) − (current − boundary).
- R3: A frame whose first byte is taken while `rx_enable` is 0 or `buf_full` is 1 is consumed up to its end byte. It causes no memory write, no `rx_irq` and no change of `cur_pg`.
- R4: The header of an accepted frame is written at byte offsets 0..3 of page `cur_pg`, in this order: status, next page, stored length + 4 (low byte), stored length + 4 (high byte).
- R5: The status byte is 0x21 when bit 0 of the frame's first byte is 1, and 0x01 otherwise.
- R6: A frame of fewer than 60 bytes is extended with 0x00 bytes to 60 bytes. A frame of 60 or more bytes is stored unchanged.
- R7: The next page is current + ⌊(stored length + 8 + 255) / 256⌋. If that value is at or above the limit page, (limit − first) is subtracted from it.
- R8: Payload byte k of a frame is written at cur_pg×256 + 4 + k. An address that reaches limit×256 continues at first×256.
- R9: One cycle after the last header write, `cur_pg` takes the next-page value and `rx_irq` is high for exactly one cycle.
- R10: `in_ready` is 0 from the cycle after the end byte is taken until `rx_irq` has been raised.
- R11: A cycle with `cur_pg_load` high sets `cur_pg` to `cur_pg_in` on the next edge. A frame completing in that cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | 1 = receiver started, 0 = stopped |
| pg_start | input | 8 | First page of the ring |
| pg_stop | input | 8 | Limit page (one past the last ring page) |
| pg_bound | input | 8 | Boundary page (host read position) |
| cur_pg_load | input | 1 | Load strobe for the current page pointer |
| cur_pg_in | input | 8 | Value for the current page pointer |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted when high together with in_valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| cur_pg | output | 8 | Current page pointer |
| buf_full | output | 1 | Ring has too little free space for a frame |
| rx_irq | output | 1 | One-cycle receive-done request |

## Verification
The bench targets the free-space formula on both sides of the 1518-byte threshold, in both of its branches and with current equal to boundary. A sign or branch error would refuse frames that fit or accept frames that overrun unread data. The next-page rounding is tested with stored lengths of 248 and 249 bytes, one on each side of a page step, and with a next page that lands exactly on the limit page. An off-by-one or a strict comparison there would leave the pointer one page off or outside the ring. One 300-byte frame crosses the limit page, and a design that failed to wrap would write beyond the ring. Short frames check that the zero fill comes before the header, and that the header reports the padded length.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_PAD,
    ST_HDR,
    ST_DONE
  } wr_state_e;

  localparam logic [7:0] STAT_GOOD  = 8'h01;
  localparam logic [7:0] STAT_GROUP = 8'h20;

endpackage

// File: rtl/rx_ring_space.sv
module rx_ring_space #(
  parameter int PG_W      = 8,
  parameter int PAGE_BITS = 8,
  parameter int MAX_LEN   = 1514,
  parameter int HDR_LEN   = 4
) (
  input  logic [PG_W-1:0] first_pg,
  input  logic [PG_W-1:0] limit_pg,
  input  logic [PG_W-1:0] bound_pg,
  input  logic [PG_W-1:0] cur_pg,
  output logic            full
);
  localparam int NEED_BYTES = MAX_LEN + HDR_LEN;
  localparam int NEED_PG    = (NEED_BYTES + (1 << PAGE_BITS) - 1) >> PAGE_BITS;
  localparam int AW         = PG_W + 2;
  localparam logic signed [AW-1:0] NEED_S = AW'(NEED_PG);

  logic signed [AW-1:0] s_first, s_limit, s_bound, s_cur, avail;

  always_comb begin
    s_first = $signed({2'b00, first_pg});
    s_limit = $signed({2'b00, limit_pg});
    s_bound = $signed({2'b00, bound_pg});
    s_cur   = $signed({2'b00, cur_pg});
    if (cur_pg < bound_pg) avail = s_bound - s_cur;
    else                   avail = (s_limit - s_first) - (s_cur - s_bound);
    full = (avail < NEED_S);
  end
endmodule

// File: rtl/rx_ring_next.sv
module rx_ring_next #(
  parameter int PG_W      = 8,
  parameter int PAGE_BITS = 8,
  parameter int LEN_W     = 16,
  parameter int HDR_LEN   = 4,
  parameter int CRC_LEN   = 4
) (
  input  logic [PG_W-1:0]  cur_pg,
  input  logic [PG_W-1:0]  first_pg,
  input  logic [PG_W-1:0]  limit_pg,
  input  logic [LEN_W-1:0] size,
  output logic [PG_W-1:0]  next_pg
);
  localparam int SW = LEN_W + 2;
  localparam logic [SW-1:0] EXTRA = SW'(HDR_LEN + CRC_LEN + (1 << PAGE_BITS) - 1);

  logic [SW-1:0] span, sum, ring, wrapped;

  always_comb begin
    span    = (SW'(size) + EXTRA) >> PAGE_BITS;
    sum     = SW'(cur_pg) + span;
    ring    = SW'(limit_pg) - SW'(first_pg);
    wrapped = (sum >= SW'(limit_pg)) ? (sum - ring) : sum;
    next_pg = PG_W'(wrapped);
  end
endmodule

// File: rtl/rx_ring_step.sv
module rx_ring_step #(
  parameter int PG_W      = 8,
  parameter int PAGE_BITS = 8,
  localparam int ADDR_W   = PG_W + PAGE_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PG_W-1:0]   first_pg,
  input  logic [PG_W-1:0]   limit_pg,
  output logic [ADDR_W-1:0] addr_next
);
  logic [ADDR_W-1:0] inc;

  always_comb begin
    inc = addr + ADDR_W'(1);
    if (inc == {limit_pg, {PAGE_BITS{1'b0}}}) addr_next = {first_pg, {PAGE_BITS{1'b0}}};
    else                                      addr_next = inc;
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int PG_W      = 8,
  parameter int PAGE_BITS = 8,
  parameter int LEN_W     = 16,
  parameter int MIN_LEN   = 60,
  parameter int MAX_LEN   = 1514,
  parameter int HDR_LEN   = 4,
  parameter int CRC_LEN   = 4,
  localparam int ADDR_W   = PG_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_enable,
  input  logic [PG_W-1:0]   pg_start,
  input  logic [PG_W-1:0]   pg_stop,
  input  logic [PG_W-1:0]   pg_bound,
  input  logic              cur_pg_load,
  input  logic [PG_W-1:0]   cur_pg_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [PG_W-1:0]   cur_pg,
  output logic              buf_full,
  output logic              rx_irq
);
  localparam int HI_W = (HDR_LEN > 1) ? $clog2(HDR_LEN) : 1;
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  wr_state_e         state_q;
  logic [ADDR_W-1:0] wr_addr_q, first_addr, run_next, first_next;
  logic [PG_W-1:0]   base_pg_q, cur_pg_q, next_pg;
  logic [LEN_W-1:0]  len_q, len_inc, total_len;
  logic [HI_W-1:0]   hdr_idx_q;
  logic              mcast_q, full_w, accept, beat;
  logic              we_q, irq_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q, hdr_byte;

  rx_ring_space #(
    .PG_W(PG_W), .PAGE_BITS(PAGE_BITS), .MAX_LEN(MAX_LEN), .HDR_LEN(HDR_LEN)
  ) u_space (
    .first_pg(pg_start), .limit_pg(pg_stop), .bound_pg(pg_bound),
    .cur_pg(cur_pg_q), .full(full_w)
  );

  rx_ring_next #(
    .PG_W(PG_W), .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W),
    .HDR_LEN(HDR_LEN), .CRC_LEN(CRC_LEN)
  ) u_next (
    .cur_pg(cur_pg_q), .first_pg(pg_start), .limit_pg(pg_stop),
    .size(len_q), .next_pg(next_pg)
  );

  rx_ring_step #(.PG_W(PG_W), .PAGE_BITS(PAGE_BITS)) u_step_run (
    .addr(wr_addr_q), .first_pg(pg_start), .limit_pg(pg_stop), .addr_next(run_next)
  );

  rx_ring_step #(.PG_W(PG_W), .PAGE_BITS(PAGE_BITS)) u_step_first (
    .addr(first_addr), .first_pg(pg_start), .limit_pg(pg_stop), .addr_next(first_next)
  );

  assign first_addr = {cur_pg_q, PAGE_BITS'(HDR_LEN)};
  assign in_ready   = (state_q == ST_IDLE) || (state_q == ST_DATA) || (state_q == ST_DROP);
  assign beat       = in_valid && in_ready;
  assign accept     = rx_enable && !full_w;
  assign len_inc    = len_q + LEN_W'(1);
  assign total_len  = len_q + LEN_W'(HDR_LEN);

  always_comb begin
    if (hdr_idx_q == HI_W'(0))
      hdr_byte = STAT_GOOD | (mcast_q ? STAT_GROUP : 8'h00);
    else if (hdr_idx_q == HI_W'(1))
      hdr_byte = 8'(next_pg);
    else if (hdr_idx_q == HI_W'(2))
      hdr_byte = total_len[7:0];
    else
      hdr_byte = 8'(total_len >> 8);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wr_addr_q <= '0;
      base_pg_q <= '0;
      len_q     <= '0;
      hdr_idx_q <= '0;
      mcast_q   <= 1'b0;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      irq_q     <= 1'b0;
    end else begin
      we_q  <= 1'b0;
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (beat && in_sof) begin
            if (accept) begin
              base_pg_q <= cur_pg_q;
              mcast_q   <= in_data[0];
              len_q     <= LEN_W'(1);
              hdr_idx_q <= '0;
              we_q      <= 1'b1;
              addr_q    <= first_addr;
              wdata_q   <= in_data;
              wr_addr_q <= first_next;
              if (in_eof) state_q <= (LEN_W'(1) < MIN_L) ? ST_PAD : ST_HDR;
              else        state_q <= ST_DATA;
            end else if (!in_eof) begin
              state_q <= ST_DROP;
            end
          end
        end
        ST_DATA: begin
          if (beat) begin
            we_q      <= 1'b1;
            addr_q    <= wr_addr_q;
            wdata_q   <= in_data;
            wr_addr_q <= run_next;
            len_q     <= len_inc;
            if (in_eof) state_q <= (len_inc < MIN_L) ? ST_PAD : ST_HDR;
          end
        end
        ST_DROP: begin
          if (beat && in_eof) state_q <= ST_IDLE;
        end
        ST_PAD: begin
          we_q      <= 1'b1;
          addr_q    <= wr_addr_q;
          wdata_q   <= 8'h00;
          wr_addr_q <= run_next;
          len_q     <= len_inc;
          if (len_inc >= MIN_L) state_q <= ST_HDR;
        end
        ST_HDR: begin
          we_q      <= 1'b1;
          addr_q    <= {base_pg_q, PAGE_BITS'(hdr_idx_q)};
          wdata_q   <= hdr_byte;
          hdr_idx_q <= hdr_idx_q + HI_W'(1);
          if (hdr_idx_q == HI_W'(HDR_LEN - 1)) state_q <= ST_DONE;
        end
        ST_DONE: begin
          irq_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     cur_pg_q <= '0;
    else if (state_q == ST_DONE) cur_pg_q <= next_pg;
    else if (cur_pg_load)        cur_pg_q <= cur_pg_in;
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign cur_pg    = cur_pg_q;
  assign buf_full  = full_w;
  assign rx_irq    = irq_q;

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int PG_W      = 8,
  parameter int PAGE_BITS = 8,
  localparam int ADDR_W   = PG_W + PAGE_BITS
) (
  input logic              clk,
  input logic              rst,
  input logic [PG_W-1:0]   pg_start,
  input logic [PG_W-1:0]   pg_stop,
  input logic              cur_pg_load,
  input logic              in_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PG_W-1:0]   cur_pg,
  input logic              rx_irq
);
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  // R9
  irq_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> ($past(mem_we) && !mem_we));

  // R10
  ready_low_before_irq_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> !$past(in_ready));

  // R8
  addr_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && (pg_start < pg_stop)) |->
      ((mem_addr[ADDR_W-1 -: PG_W] >= pg_start) && (mem_addr[ADDR_W-1 -: PG_W] < pg_stop)));

  // R11
  cur_pg_source_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_pg) |-> (rx_irq || $past(cur_pg_load)));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PG_W(PG_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst(rst), .pg_start(pg_start), .pg_stop(pg_stop),
  .cur_pg_load(cur_pg_load), .in_ready(in_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .cur_pg(cur_pg), .rx_irq(rx_irq)
);

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_enable = 1'b1;
  logic [7:0]  pg_start = 8'h40, pg_stop = 8'h80, pg_bound = 8'h40;
  logic        cur_pg_load = 1'b0;
  logic [7:0]  cur_pg_in = 8'h00;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, mem_we, buf_full, rx_irq;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_pg;

  always #5 clk = ~clk;

  rx_ring_writer i_rx_ring_writer (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .pg_start(pg_start),
    .pg_stop(pg_stop), .pg_bound(pg_bound), .cur_pg_load(cur_pg_load),
    .cur_pg_in(cur_pg_in), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_pg(cur_pg),
    .buf_full(buf_full), .rx_irq(rx_irq)
  );

  int n_checks = 0, n_err = 0, wcnt = 0, irq_cnt = 0;
  bit finished = 0;
  logic [7:0] wmem [int];
  logic [7:0] frm [$];
  logic       rdy_after_eof;

  always @(negedge clk) begin
    if (mem_we) begin wmem[int'(mem_addr)] = mem_wdata; wcnt++; end
    if (rx_irq) irq_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] s, input logic [7:0] e, input logic [7:0] c,
                     input logic [7:0] b, input logic en);
    @(negedge clk);
    pg_start = s; pg_stop = e; pg_bound = b; rx_enable = en;
    cur_pg_in = c; cur_pg_load = 1'b1;
    @(negedge clk);
    cur_pg_load = 1'b0;
  endtask

  task automatic build(input int n, input logic [7:0] first, input int seed);
    frm.delete();
    frm.push_back(first);
    for (int i = 1; i < n; i++) frm.push_back(8'((i * 7 + seed) | 1));
  endtask

  task automatic put(input logic [7:0] b, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_sof = s; in_eof = e;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic send();
    wmem.delete(); wcnt = 0;
    for (int i = 0; i < frm.size(); i++) put(frm[i], i == 0, i == frm.size() - 1);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    rdy_after_eof = in_ready;
  endtask

  // independent model of the stored image
  task automatic expect_frame(input string tag, input logic [7:0] exp_next_given);
    int cur0, base, size, total, nxt, a, bad, irq0, waited;
    logic [7:0] expb;
    cur0  = int'(cur_pg);
    base  = cur0 * 256;
    size  = (frm.size() < 60) ? 60 : frm.size();
    total = size + 4;
    nxt   = cur0 + ((total + 4 + 255) / 256);
    if (nxt >= int'(pg_stop)) nxt -= int'(pg_stop) - int'(pg_start);
    irq0 = irq_cnt;
    send();
    chk(rdy_after_eof == 1'b0, "R10", {tag, " ready after end"}, int'(rdy_after_eof), 0);
    waited = 0;
    while (irq_cnt == irq0 && waited < 3000) begin @(negedge clk); waited++; end
    chk(irq_cnt == irq0 + 1, "R9", {tag, " irq count"}, irq_cnt - irq0, 1);
    chk(int'(cur_pg) == nxt && nxt == int'(exp_next_given), "R7", {tag, " next page"}, int'(cur_pg), int'(exp_next_given));
    chk(wmem.exists(base) && int'(wmem[base]) == ((frm[0][0]) ? 'h21 : 'h01), "R5",
        {tag, " status"}, wmem.exists(base) ? int'(wmem[base]) : -1, frm[0][0] ? 'h21 : 'h01);
    chk(wmem.exists(base+1) && int'(wmem[base+1]) == nxt, "R4", {tag, " hdr next"},
        wmem.exists(base+1) ? int'(wmem[base+1]) : -1, nxt);
    chk(wmem.exists(base+3) && {wmem[base+3], wmem[base+2]} == 16'(total), "R4", {tag, " hdr length"},
        wmem.exists(base+3) ? int'({wmem[base+3], wmem[base+2]}) : -1, total);
    bad = 0;
    a = base + 4;
    for (int k = 0; k < size; k++) begin
      expb = (k < frm.size()) ? frm[k] : 8'h00;
      if (!wmem.exists(a) || wmem[a] != expb) bad++;
      a++;
      if (a == int'(pg_stop) * 256) a = int'(pg_start) * 256;
    end
    chk(bad == 0, (frm.size() < 60) ? "R6" : "R8", {tag, " payload image mismatches"}, bad, 0);
    chk(wcnt == size + 4, "R8", {tag, " write count"}, wcnt, size + 4);
    @(negedge clk);
    chk(rx_irq == 1'b0, "R9", {tag, " irq one cycle"}, int'(rx_irq), 0);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    chk(mem_we == 1'b0, "R1", "we after reset", int'(mem_we), 0);
    chk(rx_irq == 1'b0, "R1", "irq after reset", int'(rx_irq), 0);
    chk(cur_pg == 8'h00, "R1", "cur after reset", int'(cur_pg), 0);
  endtask

  task automatic t_full();
    cfg(8'h40, 8'h80, 8'h45, 8'h48, 1'b1);
    chk(buf_full == 1'b1, "R2", "below boundary 3 pages", int'(buf_full), 1);
    cfg(8'h40, 8'h80, 8'h43, 8'h48, 1'b1);
    chk(buf_full == 1'b1, "R2", "below boundary 5 pages", int'(buf_full), 1);
    cfg(8'h40, 8'h80, 8'h42, 8'h48, 1'b1);
    chk(buf_full == 1'b0, "R2", "below boundary 6 pages", int'(buf_full), 0);
    cfg(8'h40, 8'h80, 8'h7e, 8'h43, 1'b1);
    chk(buf_full == 1'b1, "R2", "above boundary 5 pages", int'(buf_full), 1);
    cfg(8'h40, 8'h80, 8'h7e, 8'h44, 1'b1);
    chk(buf_full == 1'b0, "R2", "above boundary 6 pages", int'(buf_full), 0);
    cfg(8'h40, 8'h80, 8'h50, 8'h50, 1'b1);
    chk(buf_full == 1'b0, "R2", "empty ring", int'(buf_full), 0);
  endtask

  task automatic t_load();
    cfg(8'h40, 8'h80, 8'h5a, 8'h40, 1'b1);
    chk(cur_pg == 8'h5a, "R11", "host load of current page", int'(cur_pg), 'h5a);
  endtask

  task automatic t_short_group();
    cfg(8'h40, 8'h80, 8'h40, 8'h40, 1'b1);
    build(10, 8'h01, 3);
    expect_frame("short group", 8'h41);
  endtask

  task automatic t_exact_min();
    build(60, 8'h02, 5);
    expect_frame("sixty unicast", 8'h42);
  endtask

  task automatic t_page_edge();
    build(248, 8'h00, 9);
    expect_frame("len 248", 8'h43);
    build(249, 8'hff, 11);
    expect_frame("len 249 broadcast", 8'h45);
  endtask

  task automatic t_wrap();
    cfg(8'h40, 8'h80, 8'h7f, 8'h60, 1'b1);
    build(300, 8'h04, 13);
    expect_frame("wrap 300", 8'h41);
  endtask

  task automatic t_next_at_limit();
    cfg(8'h40, 8'h80, 8'h7f, 8'h60, 1'b1);
    build(20, 8'hff, 17);
    expect_frame("next at limit", 8'h40);
  endtask

  task automatic t_refuse(input string tag, input logic [7:0] c, input logic [7:0] b, input logic en);
    int irq0;
    cfg(8'h40, 8'h80, c, b, en);
    irq0 = irq_cnt;
    build(20, 8'h02, 21);
    send();
    repeat (40) @(negedge clk);
    chk(wcnt == 0, "R3", {tag, " writes"}, wcnt, 0);
    chk(irq_cnt == irq0, "R3", {tag, " irq"}, irq_cnt - irq0, 0);
    chk(cur_pg == c, "R3", {tag, " cur page"}, int'(cur_pg), int'(c));
    chk(in_ready == 1'b1, "R3", {tag, " stream consumed"}, int'(in_ready), 1);
  endtask

  task automatic t_after_refuse();
    cfg(8'h40, 8'h80, 8'h40, 8'h40, 1'b1);
    build(61, 8'h06, 23);
    expect_frame("after refuse", 8'h41);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full();
    t_load();
    t_short_group();
    t_exact_min();
    t_page_edge();
    t_wrap();
    t_next_at_limit();
    t_refuse("full", 8'h45, 8'h48, 1'b1);
    t_refuse("stopped", 8'h40, 8'h40, 1'b0);
    t_after_refuse();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule